// File: doc/BRIEF.md
# UART Sleep Sequencer

This block decides when a UART core may stop clocking its internal logic to save power, and when that logic must start running again. Software arms the feature with a sleep-enable bit. While the bit is set, the block puts the core to sleep whenever it has no work. Work means a character in transit, a character waiting to be read, or a pending interrupt. The block also watches the serial receive line, the four modem-status inputs and the host's transmit-write strobe.

Any activity on those inputs wakes the core. The clock-enable output rises in the same cycle as the wake cause, so the triggering host write or serial edge reaches clocked logic. When the work is finished, the block lets the core fall asleep again without software help. Clearing the enable bit keeps the core awake for good.

The asynchronous line inputs pass through a synchronizer of configurable depth before edge detection. A configurable hold count sets how long the core must be quiet before it may sleep.

Top module: `uart_sleep_seq`

## Requirements
- R1: After reset the core is awake (`asleep_o`=0), `clk_en_o`=1 and sleep stays off until `sleep_en_i` is set.
- R2: With `sleep_en_i`=1 and `irq_pend_i`=0, once `thr_empty_i`, `tsr_idle_i` and `rx_empty_i` have all been high for IDLE_HOLD consecutive clock edges while still high, the next edge sets `asleep_o`=1. While asleep with no wake cause present, `clk_en_o`=0.
- R3: While any of `thr_empty_i`, `tsr_idle_i` or `rx_empty_i` is low, the core never enters sleep.
- R4: A pending interrupt (`irq_pend_i`=1) prevents sleep entry. If it appears while the core is asleep, `clk_en_o` rises in that cycle and the core is awake after the next edge.
- R5: A host write strobe (`thr_wr_i`=1) while asleep raises `clk_en_o` in the same cycle, and the core is awake after the next edge.
- R6: A high-to-low transition of `rx_i` wakes the core. `clk_en_o` rises SYNC_STAGES edges after the change and the core is awake one edge later. A low-to-high transition of `rx_i` does not wake it.
- R7: A change in either direction on any bit of `modem_i` wakes the core with the same latency as R6.
- R8: After a wake, the core returns to sleep by itself once the R2 conditions hold again, as long as `sleep_en_i` is still 1.
- R9: Clearing `sleep_en_i` while asleep raises `clk_en_o` in the same cycle, wakes the core on the next edge and keeps it awake.
- R10: Whenever the core is awake, `clk_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en_i | input | 1 | Software sleep enable |
| rx_i | input | 1 | Serial receive line, asynchronous, idles high |
| modem_i | input | NUM_MODEM | Modem-status input lines, asynchronous |
| thr_wr_i | input | 1 | Host write strobe to the transmit holding register |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tsr_idle_i | input | 1 | Transmit shift register idle |
| rx_empty_i | input | 1 | Receive buffer empty |
| irq_pend_i | input | 1 | Some interrupt is pending |
| asleep_o | output | 1 | Core is in sleep |
| clk_en_o | output | 1 | Enable for the core's gated clocks |

## Verification
The bench builds the block with IDLE_HOLD=3, SYNC_STAGES=2 and NUM_MODEM=4. The hold of three edges makes the quiet counter climb through several values before sleep entry, so an early or late entry stands out against the expected edge count. The two-stage synchronizer gives a wake latency that can be told apart from the same-cycle response to host writes and interrupts. With four modem lines, each line gets its own wake test, and one line is also exercised on a falling change.

// File: rtl/usc_pkg.sv
package usc_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } usc_state_e;

  // True once the quiet run length has reached the required hold count.
  function automatic logic hold_reached(input int unsigned run_len,
                                        input int unsigned hold);
    return run_len >= hold;
  endfunction

  // Reduction: any bit differs between two samples of a bus.
  function automatic logic any_change(input logic [31:0] now_v,
                                      input logic [31:0] was_v);
    return |(now_v ^ was_v);
  endfunction

endpackage

// File: rtl/usc_sync.sv
module usc_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/usc_activity.sv
module usc_activity
  import usc_pkg::*;
#(
  parameter int unsigned NUM_MODEM = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_s,
  input  logic [NUM_MODEM-1:0] modem_s,
  input  logic                 thr_wr,
  output logic                 start_fall,
  output logic                 modem_chg,
  output logic                 wake_evt
);

  logic                 rx_prev_q;
  logic [NUM_MODEM-1:0] modem_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q    <= 1'b1;
      modem_prev_q <= '0;
    end else begin
      rx_prev_q    <= rx_s;
      modem_prev_q <= modem_s;
    end
  end

  assign start_fall = rx_prev_q & ~rx_s;
  assign modem_chg  = any_change(32'(modem_s), 32'(modem_prev_q));
  assign wake_evt   = start_fall | modem_chg | thr_wr;

  // A falling edge leaves the line low, so it cannot repeat on the next cycle.
  AST_FALL_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall |=> !start_fall);  // R6

endmodule

// File: rtl/usc_quiet.sv
module usc_quiet
  import usc_pkg::*;
#(
  parameter int unsigned IDLE_HOLD = 1,
  localparam int unsigned CNT_W    = (IDLE_HOLD < 1) ? 1 : $clog2(IDLE_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic tsr_idle,
  input  logic rx_empty,
  input  logic wake_evt,
  output logic quiet_ok
);

  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(IDLE_HOLD);

  logic             quiet_now;
  logic [CNT_W-1:0] run_q;

  assign quiet_now = thr_empty & tsr_idle & rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!quiet_now || wake_evt) begin
      run_q <= '0;
    end else if (run_q < HOLD_C) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign quiet_ok = quiet_now & ~wake_evt &
                    hold_reached(32'(run_q), IDLE_HOLD);

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= HOLD_C);  // R2

  AST_BUSY_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet_now |=> (run_q == '0));  // R3

endmodule

// File: rtl/usc_fsm.sv
module usc_fsm
  import usc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_en,
  input  logic irq_pend,
  input  logic wake_evt,
  input  logic quiet_ok,
  output logic asleep,
  output logic clk_en
);

  usc_state_e st_q, st_d;
  logic       resume;
  logic       may_enter;

  assign resume    = ~sleep_en | wake_evt | irq_pend;
  assign may_enter = sleep_en & quiet_ok & ~irq_pend & ~wake_evt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE:  if (may_enter) st_d = ST_ASLEEP;
      ST_ASLEEP: if (resume)    st_d = ST_AWAKE;
      default:                  st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_AWAKE;
    else        st_q <= st_d;
  end

  assign asleep = (st_q == ST_ASLEEP);
  assign clk_en = ~asleep | resume;

  AST_IRQ_KEEPS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> !asleep);  // R4

  AST_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_evt) |=> !asleep);  // R5

  AST_DISABLE_FORCES_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_en |=> !asleep);  // R9

  AST_AWAKE_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> clk_en);  // R10

  AST_ENTRY_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(quiet_ok));  // R2

endmodule

// File: rtl/uart_sleep_seq.sv
module uart_sleep_seq
  import usc_pkg::*;
#(
  parameter int unsigned NUM_MODEM   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_HOLD   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_en_i,
  input  logic                 rx_i,
  input  logic [NUM_MODEM-1:0] modem_i,
  input  logic                 thr_wr_i,
  input  logic                 thr_empty_i,
  input  logic                 tsr_idle_i,
  input  logic                 rx_empty_i,
  input  logic                 irq_pend_i,
  output logic                 asleep_o,
  output logic                 clk_en_o
);

  logic                 rx_s;
  logic [NUM_MODEM-1:0] modem_s;
  logic                 start_fall;
  logic                 modem_chg;
  logic                 wake_evt;
  logic                 quiet_ok;

  usc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk (clk), .rst_n(rst_n), .din(rx_i), .dout(rx_s)
  );

  usc_sync #(.WIDTH(NUM_MODEM), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_modem_sync (
    .clk (clk), .rst_n(rst_n), .din(modem_i), .dout(modem_s)
  );

  usc_activity #(.NUM_MODEM(NUM_MODEM)) u_activity (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_s      (rx_s),
    .modem_s   (modem_s),
    .thr_wr    (thr_wr_i),
    .start_fall(start_fall),
    .modem_chg (modem_chg),
    .wake_evt  (wake_evt)
  );

  usc_quiet #(.IDLE_HOLD(IDLE_HOLD)) u_quiet (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_empty(thr_empty_i),
    .tsr_idle (tsr_idle_i),
    .rx_empty (rx_empty_i),
    .wake_evt (wake_evt),
    .quiet_ok (quiet_ok)
  );

  usc_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_en(sleep_en_i),
    .irq_pend(irq_pend_i),
    .wake_evt(wake_evt),
    .quiet_ok(quiet_ok),
    .asleep  (asleep_o),
    .clk_en  (clk_en_o)
  );

  AST_LINE_EVENT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && (start_fall || modem_chg)) |-> clk_en_o);  // R6

  AST_AUTO_REENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && !quiet_ok) |=> !asleep_o);  // R8

endmodule

// File: tb/uart_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module uart_sleep_seq_tb_top;

  localparam int NM   = 4;
  localparam int SYNC = 2;
  localparam int HOLD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_en = 1'b0;
  logic          rx = 1'b1;
  logic [NM-1:0] modem = '0;
  logic          thr_wr = 1'b0;
  logic          thr_empty = 1'b1;
  logic          tsr_idle = 1'b1;
  logic          rx_empty = 1'b1;
  logic          irq = 1'b0;
  logic          asleep;
  logic          clk_en;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  uart_sleep_seq #(.NUM_MODEM(NM), .SYNC_STAGES(SYNC), .IDLE_HOLD(HOLD)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_en_i (sleep_en),
    .rx_i       (rx),
    .modem_i    (modem),
    .thr_wr_i   (thr_wr),
    .thr_empty_i(thr_empty),
    .tsr_idle_i (tsr_idle),
    .rx_empty_i (rx_empty),
    .irq_pend_i (irq),
    .asleep_o   (asleep),
    .clk_en_o   (clk_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance n clock edges, landing just after a falling edge.
  task automatic edges(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  // Bring the core into sleep from an awake, quiet state.
  task automatic settle_asleep(input string tag);
    edges(HOLD + 3);
    chk(tag, asleep, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 asleep after reset", asleep, 1'b0);
    chk("R1 clk_en after reset", clk_en, 1'b1);
    edges(HOLD + 4);
    chk("R1 no sleep while disabled", asleep, 1'b0);
  endtask

  task automatic t_entry_timing();
    tsr_idle = 1'b0;
    sleep_en = 1'b1;
    edges(2);
    chk("R3 busy shifter keeps awake", asleep, 1'b0);
    tsr_idle = 1'b1;
    edges(HOLD);
    chk("R2 not asleep before hold done", asleep, 1'b0);
    edges(1);
    chk("R2 asleep after hold", asleep, 1'b1);
    chk("R2 clk_en off while asleep", clk_en, 1'b0);
  endtask

  task automatic t_busy_blocks();
    sleep_en = 1'b0;
    edges(1);
    sleep_en = 1'b1;
    thr_empty = 1'b0;
    edges(HOLD + 6);
    chk("R3 holding reg busy keeps awake", asleep, 1'b0);
    thr_empty = 1'b1;
    rx_empty = 1'b0;
    edges(HOLD + 6);
    chk("R3 rx data keeps awake", asleep, 1'b0);
    rx_empty = 1'b1;
    settle_asleep("R2 sleeps once quiet");
  endtask

  task automatic t_irq();
    irq = 1'b1;
    #0.5;
    chk("R4 clk_en same cycle as irq", clk_en, 1'b1);
    edges(1);
    chk("R4 irq wakes", asleep, 1'b0);
    edges(8);
    chk("R4 no entry while irq pending", asleep, 1'b0);
    irq = 1'b0;
    settle_asleep("R4 sleeps after irq clears");
  endtask

  task automatic t_host_write();
    thr_wr = 1'b1;
    #0.5;
    chk("R5 clk_en same cycle as write", clk_en, 1'b1);
    chk("R5 still asleep in write cycle", asleep, 1'b1);
    edges(1);
    thr_wr = 1'b0;
    thr_empty = 1'b0;
    #0.5;
    chk("R5 awake after write", asleep, 1'b0);
    edges(6);
    chk("R8 awake while char pending", asleep, 1'b0);
    thr_empty = 1'b1;
    edges(HOLD);
    chk("R8 not yet re-entered", asleep, 1'b0);
    edges(1);
    chk("R8 auto re-entry", asleep, 1'b1);
  endtask

  task automatic t_rx_edges();
    rx = 1'b0;
    edges(SYNC);
    chk("R6 clk_en after sync latency", clk_en, 1'b1);
    chk("R6 still asleep at latency", asleep, 1'b1);
    edges(1);
    chk("R6 start bit wakes", asleep, 1'b0);
    settle_asleep("R8 re-entry after rx wake");
    rx = 1'b1;
    for (int i = 0; i < 6; i++) begin
      edges(1);
      chk("R6 rising edge no clk_en", clk_en, 1'b0);
    end
    chk("R6 rising edge ignored", asleep, 1'b1);
  endtask

  task automatic t_modem();
    for (int i = 0; i < NM; i++) begin
      modem[i] = 1'b1;
      edges(SYNC + 1);
      chk($sformatf("R7 modem line %0d rise wakes", i), asleep, 1'b0);
      settle_asleep("R7 back asleep");
    end
    modem[0] = 1'b0;
    edges(SYNC);
    chk("R7 modem fall clk_en", clk_en, 1'b1);
    edges(1);
    chk("R7 modem fall wakes", asleep, 1'b0);
    settle_asleep("R7 back asleep after fall");
  endtask

  task automatic t_disable();
    sleep_en = 1'b0;
    #0.5;
    chk("R9 clk_en same cycle as disable", clk_en, 1'b1);
    edges(1);
    chk("R9 disable wakes", asleep, 1'b0);
    edges(HOLD + 6);
    chk("R9 stays awake", asleep, 1'b0);
    chk("R10 clk_en while awake", clk_en, 1'b1);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_entry_timing();
    t_busy_blocks();
    t_irq();
    t_host_write();
    t_rx_edges();
    t_modem();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule